// File: doc/BRIEF.md
# Platform Interrupt Controller

This block gathers level-sensitive interrupt lines from many devices and delivers one external-interrupt request to each of several targets (hardware contexts, such as one privilege level on one core). Each source has a gateway that latches an asserted line as a pending bit. Each source has a 3-bit priority. Each context has its own enable mask and priority threshold, and an arbiter that looks for the best eligible source.

Software reaches all state through a single 32-bit memory-mapped read/write port. An interrupt handler reads its context's claim/complete word. That read returns the winning source ID and clears its pending bit in the same cycle. While the source is being serviced, its gateway holds off new requests. The handler writes the same ID back to the same word to reopen the gateway. A source whose line is still high then becomes pending again.

Top module: `irq_hub`

## Requirements
- R1: After reset every pending bit, enable bit, priority and threshold is 0, both external-interrupt outputs are low, and a claim read returns 0.
- R2: Source s has a 3-bit priority at byte offset 4*s (bits 2:0, upper bits read 0). Source 0 does not exist, and its priority word always reads 0.
- R3: Line `irq_lines[s-1]` drives source s. While that line is high and the source is neither pending nor in service, the gateway sets pending bit s. Pending bits are read-only at offset 0x1000 + 4*w, where bit b of word w is source 32*w+b.
- R4: `ext_irq[c]` is registered. One clock after the state changes, it is high exactly when context c has at least one eligible source.
- R5: A source is eligible for context c only if it is pending, enabled for c, and its priority is strictly greater than c's threshold. A source with priority 0 is therefore never eligible.
- R6: A read of the claim word at 0x200004 + 0x1000*c returns the ID of c's best eligible source, or 0 if none, with `bus_rvalid` high one clock after the read. In the same clock it clears that source's pending bit.
- R7: Among eligible sources of equal priority, the lowest ID wins.
- R8: A claimed source stays non-pending until a complete write names it, even while its line stays high. After the complete, the line is sampled again: if it is high the source is pending again, and if it is low it is not.
- R9: A complete write to context c that names a source not enabled for c (or ID 0, or an ID out of range) has no effect.
- R10: Enable bits for context c are at 0x2000 + 0x80*c + 4*w, with bit b of word w meaning source 32*w+b. Bit 0 of word 0 always reads 0.
- R11: Context c's threshold is at 0x200000 + 0x1000*c (bits 2:0). Contexts arbitrate independently, each with its own mask and threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High one cycle after a read |
| irq_lines | input | NUM_SRC | Level-sensitive device lines; bit s-1 is source s |
| ext_irq | output | NUM_CTX | Registered external-interrupt request per context |

## Verification
The bench targets the following corner cases:

- **Threshold equal to the priority.** A design that compared with "greater or equal" would raise the output when it should stay low. The bench also gives a pending source priority 0; a design that let it through would raise the output or return it on a claim.
- **Three sources claimed back to back, two of them tied.** A wrong tie rule would return the IDs out of order. A claim that did not clear the pending bit would return the same ID twice. A drained context must read 0.
- **Completes.** The bench sends a complete naming a source the context has not enabled; a design that honoured it would re-pend that source. It also completes a source whose line has dropped, which must not re-pend.
- **A second context.** It uses its own threshold and claims a source that is shared with the first context. A design that shared masks or thresholds between contexts would show the wrong output levels.

// File: rtl/irq_hub_pkg.sv
// Shared types and fixed address offsets for the platform interrupt controller.
// Assumes byte addressing with word-aligned accesses.
package irq_hub_pkg;

    // Register regions reachable through the bus port
    typedef enum logic [2:0] {
        RG_NONE,
        RG_PRIO,
        RG_PEND,
        RG_EN,
        RG_THR,
        RG_CLAIM
    } region_e;

    localparam int unsigned PEND_BASE   = 32'h0000_1000;
    localparam int unsigned EN_BASE     = 32'h0000_2000;
    localparam int unsigned EN_STRIDE   = 32'h0000_0080;
    localparam int unsigned CTX_BASE    = 32'h0020_0000;
    localparam int unsigned CTX_STRIDE  = 32'h0000_1000;
    localparam int unsigned CLAIM_OFS   = 32'h0000_0004;

endpackage

// File: rtl/irq_hub_gateway.sv
// One source gateway: latches a high level-sensitive line into a pending bit,
// hands it to service on a claim and re-arms on a complete.
// Assumes claim and complete never arrive in the same cycle (single bus port).
module irq_hub_gateway (
    input  logic clk,
    input  logic rst_n,
    input  logic line,
    input  logic claim,
    input  logic complete,
    output logic pending,
    output logic busy
);

    // Pending / in-service state of the source
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            busy    <= 1'b0;
        end else if (claim) begin
            pending <= 1'b0;
            busy    <= 1'b1;
        end else if (complete) begin
            busy    <= 1'b0;
        end else if (line && !pending && !busy) begin
            pending <= 1'b1;
        end
    end

endmodule

// File: rtl/irq_hub_arbiter.sv
// Per-context arbiter: picks the pending, enabled source whose priority is
// strictly above the threshold; higher priority wins, lowest ID breaks ties.
// Assumes bit 0 of the vectors is the non-existent source 0.
module irq_hub_arbiter #(
    parameter int NUM_SRC = 31,
    parameter int PRIO_W  = 3,
    localparam int VEC_W  = NUM_SRC + 1,
    localparam int ID_W   = $clog2(VEC_W)
) (
    input  logic [VEC_W-1:0]        pend,
    input  logic [VEC_W-1:0]        en,
    input  logic [VEC_W*PRIO_W-1:0] prio,
    input  logic [PRIO_W-1:0]       thr,
    output logic [ID_W-1:0]         best_id,
    output logic                    any
);

    logic [PRIO_W-1:0] best_p;
    logic [PRIO_W-1:0] p;

    // Scan downward so that an equal priority found later (lower ID) replaces
    always_comb begin
        best_id = '0;
        best_p  = '0;
        p       = '0;
        for (int s = NUM_SRC; s >= 1; s--) begin
            p = prio[s*PRIO_W +: PRIO_W];
            if (pend[s] && en[s] && (p > thr) && (p >= best_p)) begin
                best_id = ID_W'(s);
                best_p  = p;
            end
        end
    end

    // At least one eligible source
    assign any = (best_id != '0);

endmodule

// File: rtl/irq_hub_decode.sv
// Address decoder: maps a byte address to a register region and the source,
// word and context index it selects. Out-of-range addresses map to RG_NONE.
module irq_hub_decode
    import irq_hub_pkg::*;
#(
    parameter int NUM_SRC = 31,
    parameter int NUM_CTX = 2,
    parameter int ADDR_W  = 24,
    localparam int VEC_W     = NUM_SRC + 1,
    localparam int ID_W      = $clog2(VEC_W),
    localparam int NUM_WORDS = (VEC_W + 31) / 32,
    localparam int WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
    localparam int CTX_W     = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [ID_W-1:0]   src_id,
    output logic [WIDX_W-1:0] word_idx,
    output logic [CTX_W-1:0]  ctx_idx
);

    int unsigned a;
    int unsigned rel;
    int unsigned cx;

    // Region and index decode
    always_comb begin
        a        = 32'(addr);
        region   = RG_NONE;
        src_id   = '0;
        word_idx = '0;
        ctx_idx  = '0;
        rel      = 0;
        cx       = 0;
        if (a[1:0] != 2'b00) begin
            region = RG_NONE;
        end else if (a < PEND_BASE) begin
            if ((a >> 2) >= 1 && (a >> 2) <= NUM_SRC) begin
                region = RG_PRIO;
                src_id = ID_W'(a >> 2);
            end
        end else if (a < PEND_BASE + 4 * NUM_WORDS) begin
            region   = RG_PEND;
            word_idx = WIDX_W'((a - PEND_BASE) >> 2);
        end else if (a >= EN_BASE && a < EN_BASE + EN_STRIDE * NUM_CTX) begin
            rel = a - EN_BASE;
            if ((rel % EN_STRIDE) / 4 < NUM_WORDS) begin
                region   = RG_EN;
                ctx_idx  = CTX_W'(rel / EN_STRIDE);
                word_idx = WIDX_W'((rel % EN_STRIDE) / 4);
            end
        end else if (a >= CTX_BASE) begin
            rel = a - CTX_BASE;
            cx  = rel / CTX_STRIDE;
            if (cx < NUM_CTX) begin
                ctx_idx = CTX_W'(cx);
                if (rel % CTX_STRIDE == 0)              region = RG_THR;
                else if (rel % CTX_STRIDE == CLAIM_OFS) region = RG_CLAIM;
            end
        end
    end

endmodule

// File: rtl/irq_hub.sv
// Platform interrupt controller top: source gateways, priority/enable/threshold
// registers, per-context arbiters with registered outputs, and a claim/complete
// word per context, all behind a 32-bit read/write port with one-cycle reads.
// Assumes one bus access per cycle and word-aligned addresses.
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter int NUM_SRC = 31,
    parameter int NUM_CTX = 2,
    parameter int PRIO_W  = 3,
    parameter int ADDR_W  = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               bus_rvalid,
    input  logic [NUM_SRC-1:0] irq_lines,
    output logic [NUM_CTX-1:0] ext_irq
);

    localparam int VEC_W     = NUM_SRC + 1;
    localparam int ID_W      = $clog2(VEC_W);
    localparam int NUM_WORDS = (VEC_W + 31) / 32;
    localparam int WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam int CTX_W     = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;
    localparam int PAD_W     = NUM_WORDS * 32;

    region_e                         region;
    logic [ID_W-1:0]                 src_id;
    logic [WIDX_W-1:0]               word_idx;
    logic [CTX_W-1:0]                ctx_idx;

    logic [VEC_W-1:0][PRIO_W-1:0]    prio_q;
    logic [NUM_CTX-1:0][VEC_W-1:0]   en_q;
    logic [NUM_CTX-1:0][PRIO_W-1:0]  thr_q;
    logic [VEC_W-1:0]                pend_vec;
    logic [VEC_W-1:0]                busy_vec;
    logic [VEC_W-1:0]                claim_vec;
    logic [VEC_W-1:0]                cmp_vec;
    logic [NUM_CTX-1:0][ID_W-1:0]    best_id;
    logic [NUM_CTX-1:0]              any_elig;
    logic [PAD_W-1:0]                pend_pad;
    logic [PAD_W-1:0]                en_pad;
    logic                            wr_hit;
    logic                            rd_hit;
    logic [ID_W-1:0]                 cmp_id;

    irq_hub_decode #(
        .NUM_SRC (NUM_SRC),
        .NUM_CTX (NUM_CTX),
        .ADDR_W  (ADDR_W)
    ) i_decode (
        .addr     (bus_addr),
        .region   (region),
        .src_id   (src_id),
        .word_idx (word_idx),
        .ctx_idx  (ctx_idx)
    );

    assign wr_hit = bus_sel && bus_we;
    assign rd_hit = bus_sel && !bus_we;
    assign cmp_id = bus_wdata[ID_W-1:0];

    // Source 0 does not exist: tie its state off
    assign pend_vec[0] = 1'b0;
    assign busy_vec[0] = 1'b0;

    // One gateway per real source
    for (genvar s = 1; s <= NUM_SRC; s++) begin : g_gw
        irq_hub_gateway i_gw (
            .clk      (clk),
            .rst_n    (rst_n),
            .line     (irq_lines[s-1]),
            .claim    (claim_vec[s]),
            .complete (cmp_vec[s]),
            .pending  (pend_vec[s]),
            .busy     (busy_vec[s])
        );
    end

    // One arbiter and one registered output per context
    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        irq_hub_arbiter #(
            .NUM_SRC (NUM_SRC),
            .PRIO_W  (PRIO_W)
        ) i_arb (
            .pend    (pend_vec),
            .en      (en_q[c]),
            .prio    (prio_q),
            .thr     (thr_q[c]),
            .best_id (best_id[c]),
            .any     (any_elig[c])
        );

        // Registered external-interrupt request
        always_ff @(posedge clk) begin
            if (!rst_n) ext_irq[c] <= 1'b0;
            else        ext_irq[c] <= any_elig[c];
        end
    end

    // Claim pulse to the winning gateway on a claim read
    always_comb begin
        claim_vec = '0;
        if (rd_hit && region == RG_CLAIM && best_id[ctx_idx] != '0)
            claim_vec[best_id[ctx_idx]] = 1'b1;
    end

    // Complete pulse only for an in-range source enabled for that context
    always_comb begin
        cmp_vec = '0;
        if (wr_hit && region == RG_CLAIM && bus_wdata < 32'(VEC_W)
                && cmp_id != '0 && en_q[ctx_idx][cmp_id])
            cmp_vec[cmp_id] = 1'b1;
    end

    // Source priority registers (source 0 stays 0)
    always_ff @(posedge clk) begin
        if (!rst_n)
            prio_q <= '0;
        else if (wr_hit && region == RG_PRIO)
            prio_q[src_id] <= bus_wdata[PRIO_W-1:0];
    end

    // Per-context enable masks (bit 0 stays 0)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_hit && region == RG_EN) begin
            for (int b = 1; b < VEC_W; b++) begin
                if (b / 32 == int'(word_idx))
                    en_q[ctx_idx][b] <= bus_wdata[b % 32];
            end
        end
    end

    // Per-context thresholds
    always_ff @(posedge clk) begin
        if (!rst_n)
            thr_q <= '0;
        else if (wr_hit && region == RG_THR)
            thr_q[ctx_idx] <= bus_wdata[PRIO_W-1:0];
    end

    // Zero-padded views for word-wide reads
    always_comb begin
        pend_pad = '0;
        en_pad   = '0;
        pend_pad[VEC_W-1:0] = pend_vec;
        en_pad[VEC_W-1:0]   = en_q[ctx_idx];
    end

    // Registered read data and response strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= rd_hit;
            if (rd_hit) begin
                case (region)
                    RG_PRIO:  bus_rdata <= 32'(prio_q[src_id]);
                    RG_PEND:  bus_rdata <= pend_pad[32*int'(word_idx) +: 32];
                    RG_EN:    bus_rdata <= en_pad[32*int'(word_idx) +: 32];
                    RG_THR:   bus_rdata <= 32'(thr_q[ctx_idx]);
                    RG_CLAIM: bus_rdata <= 32'(best_id[ctx_idx]);
                    default:  bus_rdata <= '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/irq_hub_checker.sv
// Assertion checker bound to irq_hub; observes the bus port, the outputs and
// the gateway state vectors.
module irq_hub_checker #(
    parameter int VEC_W   = 32,
    parameter int ID_W    = 5,
    parameter int NUM_CTX = 2,
    parameter int ADDR_W  = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_sel,
    input logic               bus_we,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_rvalid,
    input logic [NUM_CTX-1:0] ext_irq,
    input logic [VEC_W-1:0]   pend,
    input logic [VEC_W-1:0]   busy,
    input logic [ID_W-1:0]    best0
);

    logic claim0;
    assign claim0 = bus_sel && !bus_we && (bus_addr == ADDR_W'(32'h0020_0004));

    AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we) |=> bus_rvalid); // R6
    AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        ext_irq[0] |-> $past(|pend)); // R4
    AST_CLAIM_TAKES_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (claim0 && best0 != '0) |=> (!pend[$past(best0)] && busy[$past(best0)])); // R6
    AST_PEND_BUSY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (pend & busy) == '0); // R8
    AST_RELEASE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(busy) & ~busy)) |-> $past(bus_sel && bus_we)); // R8

endmodule

bind irq_hub irq_hub_checker #(
    .VEC_W   (VEC_W),
    .ID_W    (ID_W),
    .NUM_CTX (NUM_CTX),
    .ADDR_W  (ADDR_W)
) i_irq_hub_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_rvalid (bus_rvalid),
    .ext_irq    (ext_irq),
    .pend       (pend_vec),
    .busy       (busy_vec),
    .best0      (best_id[0])
);

// File: tb/test_irq_hub.sv
// Scoreboard bench: read tasks queue expected data, a monitor compares on
// bus_rvalid; output levels are checked directly.
module test_irq_hub;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_SRC    = 31;
    localparam int NUM_CTX    = 2;
    localparam int ADDR_W     = 24;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               bus_sel = 1'b0;
    logic               bus_we = 1'b0;
    logic [ADDR_W-1:0]  bus_addr = '0;
    logic [31:0]        bus_wdata = '0;
    logic [31:0]        bus_rdata;
    logic               bus_rvalid;
    logic [NUM_SRC-1:0] irq_lines = '0;
    logic [NUM_CTX-1:0] ext_irq;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    finished = 1'b0;
    int    exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_hub #(
        .NUM_SRC (NUM_SRC),
        .NUM_CTX (NUM_CTX),
        .ADDR_W  (ADDR_W)
    ) i_irq_hub (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .irq_lines  (irq_lines),
        .ext_irq    (ext_irq)
    );

    // Monitor: pop expected read data whenever a response appears
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fails++;
                $display("FAIL R6 unexpected response: actual %h expected none", bus_rdata);
            end else begin
                automatic int    e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (bus_rdata !== 32'(e)) begin
                    n_fails++;
                    $display("FAIL %s: actual %h expected %h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = 32'(d);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input int a, input int e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = ADDR_W'(a);
        @(negedge clk);
        bus_sel = 1'b0;
        @(negedge clk);
    endtask

    task automatic chk_irq(input int c, input bit e, input string t);
        @(negedge clk);
        n_checks++;
        if (ext_irq[c] !== e) begin
            n_fails++;
            $display("FAIL %s: ext_irq[%0d] actual %b expected %b", t, c, ext_irq[c], e);
        end
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    localparam int PEND  = 32'h1000;
    localparam int EN0   = 32'h2000;
    localparam int EN1   = 32'h2080;
    localparam int THR0  = 32'h20_0000;
    localparam int THR1  = 32'h20_1000;
    localparam int CLM0  = 32'h20_0004;
    localparam int CLM1  = 32'h20_1004;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd(PEND, 0, "R1 pending after reset");
        rd(4*5, 0, "R1 priority after reset");
        rd(EN0, 0, "R1 enable after reset");
        chk_irq(0, 1'b0, "R1 ctx0 output after reset");
        chk_irq(1, 1'b0, "R1 ctx1 output after reset");
        rd(CLM0, 0, "R1 claim with nothing pending");
        // R2: priority width and reserved source 0
        wr(0, 7);
        rd(0, 0, "R2 source 0 priority stays 0");
        wr(4*5, 32'hFF);
        rd(4*5, 7, "R2 priority keeps 3 bits");
        // R3: gateway latches line of source 5 (irq_lines[4])
        irq_lines[4] = 1'b1;
        settle();
        rd(PEND, 1 << 5, "R3 pending bit 5");
        chk_irq(0, 1'b0, "R4 not enabled keeps output low");
        // R10: enable with bit 0 forced to 0
        wr(EN0, (1 << 5) | 1);
        rd(EN0, 1 << 5, "R10 enable readback, bit0 zero");
        settle();
        chk_irq(0, 1'b1, "R4 ctx0 output high");
        chk_irq(1, 1'b0, "R11 ctx1 unaffected");
        // R5: strict threshold compare
        wr(THR0, 7);
        settle();
        chk_irq(0, 1'b0, "R5 priority equal threshold");
        wr(THR0, 6);
        settle();
        chk_irq(0, 1'b1, "R5 priority above threshold");
        wr(THR0, 0);
        // R6/R7: three sources, two tied
        wr(4*9, 3);
        wr(4*12, 3);
        irq_lines[8]  = 1'b1;
        irq_lines[11] = 1'b1;
        wr(EN0, (1 << 5) | (1 << 9) | (1 << 12));
        settle();
        rd(CLM0, 5, "R6 claim highest priority");
        rd(PEND, (1 << 9) | (1 << 12), "R8 claimed source stays clear");
        rd(CLM0, 9, "R7 tie goes to lowest ID");
        rd(CLM0, 12, "R6 next claim");
        rd(CLM0, 0, "R6 claim when drained");
        settle();
        chk_irq(0, 1'b0, "R4 output low when drained");
        // R9: complete to a context without source 9 enabled
        wr(CLM1, 9);
        settle();
        rd(PEND, 0, "R9 foreign complete ignored");
        // R8: complete re-arms a line that is still high
        wr(CLM0, 9);
        settle();
        rd(PEND, 1 << 9, "R8 re-pend after complete");
        chk_irq(0, 1'b1, "R4 output back high");
        // R5: priority 0 source never eligible
        irq_lines[19] = 1'b1;
        wr(EN1, 1 << 20);
        rd(EN1, 1 << 20, "R10 ctx1 enable readback");
        settle();
        rd(PEND, (1 << 9) | (1 << 20), "R3 priority-0 source still pends");
        chk_irq(1, 1'b0, "R5 priority 0 never interrupts");
        rd(CLM1, 0, "R5 claim skips priority 0");
        // R11: ctx1 with its own threshold
        wr(THR1, 2);
        wr(EN1, (1 << 9) | (1 << 20));
        rd(THR1, 2, "R11 ctx1 threshold readback");
        settle();
        chk_irq(1, 1'b1, "R11 ctx1 output high");
        rd(CLM1, 9, "R11 ctx1 claims shared source");
        settle();
        chk_irq(0, 1'b0, "R8 ctx0 drops after ctx1 claim");
        // R8: complete with line low does not re-pend
        irq_lines[4] = 1'b0;
        wr(CLM0, 5);
        settle();
        rd(PEND, 1 << 20, "R8 low line not re-pended");
        settle();
        if (exp_q.size() != 0) begin
            n_checks++;
            n_fails++;
            $display("FAIL R6 missing responses: actual %0d pending expected 0", exp_q.size());
        end
        finished = 1'b1;
    end

    // Watchdog and summary
    initial begin
        fork
            wait (finished);
            begin
                repeat (100000) @(posedge clk);
                n_checks++;
                n_fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule